// File: doc/BRIEF.md
# Sample-Clocked Waveform Output Buffer with Cyclic Replay

This block sits between a host that writes output samples and a converter that takes one sample each time a sample-clock enable pulses. Samples are held in an on-chip circular buffer. The host pushes words through a valid/ready port, picks a mode and issues a start pulse. From then on, every cycle in which the one-cycle tick enable is high moves the next sample onto the output register.

Two modes are offered. Streaming consumes every stored sample exactly once, and the host has to keep the buffer from running dry. If a tick arrives while the buffer is empty, a sticky error flag is raised and the output keeps its last value. Replay captures the current buffer contents as a pattern at start. It then plays that pattern again and again, going back to the first sample after the last one. Host writes are refused while replay runs. The pattern does not depend on the tick rate, so one loaded pattern can be played at any output rate and restarted without being reloaded. A stop pulse returns the block to idle. A flush pulse while idle empties the buffer so that a new pattern can be loaded.

Top module: `wave_replay_fifo`

## Requirements
- R1: After reset, smp_out is 0, underflow is 0, streaming and replaying are 0, and wr_ready is 1.
- R2: While idle, a write is accepted on each cycle where wr_valid and wr_ready are both high, until DEPTH samples are held. wr_ready is then low, and a write offered while it is low is dropped.
- R3: In streaming mode (mode_regen = 0 at start), each tick presents the oldest unread sample on smp_out after that clock edge. Every sample is presented once, in write order.
- R4: smp_out changes only at a clock edge where tick is high.
- R5: A tick in streaming mode with no stored sample sets underflow, and smp_out keeps its previous value.
- R6: underflow stays set until err_clr is high on a clock edge without a new underflow in the same cycle. A new underflow takes priority over the clear.
- R7: In replay mode (mode_regen = 1 at start), the N samples held at start are presented cyclically in write order. The first sample follows the Nth.
- R8: While replaying is high, wr_ready is low and writes leave the pattern unchanged.
- R9: Replay output does not depend on the spacing of ticks. After stop and a new start in replay mode, playback begins again at the first sample without any reload.
- R10: In streaming mode, the host may write while samples are being read, and such samples are later presented in order.
- R11: A flush pulse while idle discards all stored samples, so the next streaming tick underflows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_valid | input | 1 | Host offers a sample |
| wr_data | input | DATA_W | Sample offered by the host |
| wr_ready | output | 1 | Buffer can take a sample this cycle |
| mode_regen | input | 1 | Mode taken at start: 1 replay, 0 streaming |
| start | input | 1 | Begin output from idle |
| stop | input | 1 | Return to idle |
| flush | input | 1 | Empty the buffer while idle |
| tick | input | 1 | One-cycle sample-clock enable |
| err_clr | input | 1 | Clear the underflow flag |
| smp_out | output | DATA_W | Current output sample |
| streaming | output | 1 | Running in streaming mode |
| replaying | output | 1 | Running in replay mode |
| underflow | output | 1 | Sticky underflow error |

## Verification
The bench builds the block with its defaults: DEPTH = 2047 and DATA_W = 16. At that depth it can fill the buffer completely and drain it tick by tick. The full case of R2 is therefore exercised at the true limit, and the read and write pointers wrap past the non-power-of-two end of the array. Short patterns of three samples keep the cyclic wrap of R7 and the rate independence of R9 visible within a few ticks.

// File: rtl/wrf_pkg.sv
// Shared types for the waveform replay buffer.
package wrf_pkg;
    // Run state of the output side
    typedef enum logic [1:0] {
        RUN_IDLE   = 2'd0,
        RUN_STREAM = 2'd1,
        RUN_REPLAY = 2'd2
    } run_e;
endpackage

// File: rtl/wrf_mem.sv
// Sample storage: one write port and one read port whose result is
// registered. The read register is the block's output sample.
// Assumes that the addresses are always below DEPTH.
module wrf_mem #(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 2047,
    parameter int PTR_W  = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [PTR_W-1:0]  wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic [PTR_W-1:0]  rd_addr,
    output logic [DATA_W-1:0] rd_q
);
    logic [DATA_W-1:0] store [DEPTH];

    // Write accepted host samples into the array
    always_ff @(posedge clk) begin
        if (wr_en) store[wr_addr] <= wr_data;
    end

    // Load the output register on a read, otherwise keep its value
    always_ff @(posedge clk) begin
        if (!rst_n)     rd_q <= '0;
        else if (rd_en) rd_q <= store[rd_addr];
    end
endmodule

// File: rtl/wrf_ctrl.sv
// Control for the replay buffer: the circular write and read pointers,
// the fill count, the mode state machine, replay indexing and the sticky
// underflow flag. Assumes that tick is a one-cycle enable. The pattern
// length is taken from the fill count when start is seen.
module wrf_ctrl
    import wrf_pkg::*;
#(
    parameter int DEPTH = 2047,
    parameter int PTR_W = 11,
    parameter int CNT_W = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_valid,
    input  logic             mode_regen,
    input  logic             start,
    input  logic             stop,
    input  logic             flush,
    input  logic             tick,
    input  logic             err_clr,
    output logic             wr_ready,
    output logic             wr_en,
    output logic [PTR_W-1:0] wr_addr,
    output logic             rd_en,
    output logic [PTR_W-1:0] rd_addr,
    output logic             streaming,
    output logic             replaying,
    output logic             underflow
);
    localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

    run_e             st;
    logic [PTR_W-1:0] wptr, rptr, base, rp;
    logic [CNT_W-1:0] cnt, len, idx;
    logic             uf_evt, st_rd;

    function automatic logic [PTR_W-1:0] step(input logic [PTR_W-1:0] p);
        return (p == LAST_PTR) ? '0 : p + 1'b1;
    endfunction

    assign streaming = (st == RUN_STREAM);
    assign replaying = (st == RUN_REPLAY);
    assign wr_ready  = !replaying && (cnt != FULL_CNT);
    assign wr_en     = wr_valid && wr_ready;
    assign wr_addr   = wptr;
    assign st_rd     = tick && streaming && (cnt != '0);
    assign rd_en     = st_rd || (tick && replaying && (len != '0));
    assign rd_addr   = replaying ? rp : rptr;
    assign uf_evt    = tick && (streaming || replaying) && !rd_en;

    // Mode state machine, the pointers and the replay position
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st   <= RUN_IDLE;
            wptr <= '0;
            rptr <= '0;
            base <= '0;
            rp   <= '0;
            len  <= '0;
            idx  <= '0;
        end else begin
            if (wr_en) wptr <= step(wptr);
            case (st)
                RUN_IDLE: begin
                    if (flush) begin
                        rptr <= wptr;
                    end else if (start && !stop) begin
                        st   <= mode_regen ? RUN_REPLAY : RUN_STREAM;
                        base <= rptr;
                        rp   <= rptr;
                        len  <= cnt;
                        idx  <= '0;
                    end
                end
                RUN_STREAM: begin
                    if (stop)  st   <= RUN_IDLE;
                    if (st_rd) rptr <= step(rptr);
                end
                RUN_REPLAY: begin
                    if (stop) st <= RUN_IDLE;
                    if (rd_en) begin
                        if (idx == len - 1'b1) begin
                            rp  <= base;
                            idx <= '0;
                        end else begin
                            rp  <= step(rp);
                            idx <= idx + 1'b1;
                        end
                    end
                end
                default: st <= RUN_IDLE;
            endcase
        end
    end

    // Fill count: flush empties it, otherwise writes add and streaming reads remove
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (flush && st == RUN_IDLE)
            cnt <= wr_en ? CNT_W'(1) : '0;
        else
            cnt <= cnt + CNT_W'(wr_en) - CNT_W'(st_rd);
    end

    // Sticky underflow flag: a new event wins over a clear
    always_ff @(posedge clk) begin
        if (!rst_n)       underflow <= 1'b0;
        else if (uf_evt)  underflow <= 1'b1;
        else if (err_clr) underflow <= 1'b0;
    end
endmodule

// File: rtl/wave_replay_fifo.sv
// Waveform output buffer. Host samples enter through a valid/ready port.
// Each tick pulse moves one sample to smp_out, either consumed once
// (streaming) or replayed cyclically from a pattern captured at start.
// Assumes a single clock domain and that tick lasts one cycle.
module wave_replay_fifo #(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 2047
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_valid,
    input  logic [DATA_W-1:0] wr_data,
    output logic              wr_ready,
    input  logic              mode_regen,
    input  logic              start,
    input  logic              stop,
    input  logic              flush,
    input  logic              tick,
    input  logic              err_clr,
    output logic [DATA_W-1:0] smp_out,
    output logic              streaming,
    output logic              replaying,
    output logic              underflow
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic             wr_en, rd_en;
    logic [PTR_W-1:0] wr_addr, rd_addr;

    wrf_ctrl #(.DEPTH(DEPTH), .PTR_W(PTR_W), .CNT_W(CNT_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .mode_regen(mode_regen),
        .start(start), .stop(stop), .flush(flush), .tick(tick), .err_clr(err_clr),
        .wr_ready(wr_ready), .wr_en(wr_en), .wr_addr(wr_addr), .rd_en(rd_en),
        .rd_addr(rd_addr), .streaming(streaming), .replaying(replaying),
        .underflow(underflow)
    );

    wrf_mem #(.DATA_W(DATA_W), .DEPTH(DEPTH), .PTR_W(PTR_W)) u_mem (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_en(rd_en), .rd_addr(rd_addr), .rd_q(smp_out)
    );
endmodule

// File: rtl/wrf_chk.sv
// Protocol checks on the ports of wave_replay_fifo, attached by bind.
module wrf_chk #(
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tick,
    input logic              err_clr,
    input logic              wr_ready,
    input logic              streaming,
    input logic              replaying,
    input logic              underflow,
    input logic [DATA_W-1:0] smp_out
);
    // R4
    out_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(smp_out));
    // R8
    replay_blocks_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        replaying |-> !wr_ready);
    // R6
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        underflow && !err_clr |=> underflow);
    // R6
    err_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_clr && !tick |=> !underflow);
    // R5
    hold_on_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(underflow) |-> $stable(smp_out));
    // R3 R7
    one_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({streaming, replaying}));
endmodule

bind wave_replay_fifo wrf_chk #(.DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .tick(tick), .err_clr(err_clr),
    .wr_ready(wr_ready), .streaming(streaming), .replaying(replaying),
    .underflow(underflow), .smp_out(smp_out)
);

// File: tb/sim_wave_replay_fifo.sv
module sim_wave_replay_fifo;
    localparam int CLK_PERIOD = 10;
    localparam int DATA_W     = 16;
    localparam int DEPTH      = 2047;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              wr_valid = 1'b0;
    logic [DATA_W-1:0] wr_data = '0;
    logic              wr_ready;
    logic              mode_regen = 1'b0;
    logic              start = 1'b0;
    logic              stop = 1'b0;
    logic              flush = 1'b0;
    logic              tick = 1'b0;
    logic              err_clr = 1'b0;
    logic [DATA_W-1:0] smp_out;
    logic              streaming, replaying, underflow;

    int n_run  = 0;
    int n_fail = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    wave_replay_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_data(wr_data),
        .wr_ready(wr_ready), .mode_regen(mode_regen), .start(start), .stop(stop),
        .flush(flush), .tick(tick), .err_clr(err_clr), .smp_out(smp_out),
        .streaming(streaming), .replaying(replaying), .underflow(underflow)
    );

    // Count one check and report it if it failed
    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic chk_eq(input string req, input int act, input int exp);
        chk(act == exp, req, act, exp);
    endtask

    // Offer one sample for one cycle (inputs change at the falling edge)
    task automatic push(input logic [DATA_W-1:0] d);
        @(negedge clk);
        wr_valid = 1'b1;
        wr_data  = d;
        @(negedge clk);
        wr_valid = 1'b0;
    endtask

    // Pulse one control input for one cycle
    task automatic pulse(ref logic sig);
        @(negedge clk);
        sig = 1'b1;
        @(negedge clk);
        sig = 1'b0;
    endtask

    // One tick, then idle gap cycles; the result is visible at return
    task automatic do_tick(input int gap);
        @(negedge clk);
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
        repeat (gap) @(negedge clk);
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk_eq("R1 smp_out", smp_out, 0);
        chk_eq("R1 underflow", underflow, 0);
        chk_eq("R1 modes", {streaming, replaying}, 0);
        chk_eq("R1 wr_ready", wr_ready, 1);
    endtask

    task automatic t_stream;
        for (int i = 0; i < 4; i++) push(DATA_W'(16'h100 + i));
        mode_regen = 1'b0;
        pulse(start);
        chk_eq("R3 streaming", streaming, 1);
        for (int i = 0; i < 2; i++) begin
            do_tick(0);
            chk_eq("R3 order", smp_out, 16'h100 + i);
        end
        repeat (3) @(negedge clk);
        chk_eq("R4 no tick hold", smp_out, 16'h101);
        chk_eq("R10 ready while streaming", wr_ready, 1);
        push(16'h1AA);
        for (int i = 2; i < 4; i++) begin
            do_tick(1);
            chk_eq("R3 order", smp_out, 16'h100 + i);
        end
        do_tick(0);
        chk_eq("R10 late write", smp_out, 16'h1AA);
        chk_eq("R5 no early error", underflow, 0);
        do_tick(0);
        chk_eq("R5 underflow set", underflow, 1);
        chk_eq("R5 output held", smp_out, 16'h1AA);
        repeat (4) @(negedge clk);
        chk_eq("R6 sticky", underflow, 1);
        @(negedge clk);
        err_clr = 1'b1;
        tick    = 1'b1;
        @(negedge clk);
        err_clr = 1'b0;
        tick    = 1'b0;
        chk_eq("R6 set wins over clear", underflow, 1);
        pulse(err_clr);
        chk_eq("R6 cleared", underflow, 0);
        pulse(stop);
        chk_eq("R3 stopped", streaming, 0);
    endtask

    task automatic t_full;
        for (int i = 0; i < DEPTH; i++) push(DATA_W'(i * 7 + 1));
        chk_eq("R2 full ready low", wr_ready, 0);
        push(16'hDEAD);
        mode_regen = 1'b0;
        pulse(start);
        begin
            int bad = 0;
            int first_bad_act = 0;
            int first_bad_exp = 0;
            for (int i = 0; i < DEPTH; i++) begin
                do_tick(0);
                if (smp_out != DATA_W'(i * 7 + 1) && bad == 0) begin
                    bad = 1;
                    first_bad_act = smp_out;
                    first_bad_exp = int'(DATA_W'(i * 7 + 1));
                end
            end
            chk(bad == 0, "R2 full drain order", first_bad_act, first_bad_exp);
        end
        chk_eq("R2 no error at depth", underflow, 0);
        do_tick(0);
        chk_eq("R2 dropped write absent", underflow, 1);
        pulse(err_clr);
        pulse(stop);
    endtask

    task automatic t_replay;
        logic [DATA_W-1:0] pat [3];
        pat[0] = 16'h0A0A; pat[1] = 16'h0B0B; pat[2] = 16'h0C0C;
        pulse(flush);
        for (int i = 0; i < 3; i++) push(pat[i]);
        mode_regen = 1'b1;
        pulse(start);
        mode_regen = 1'b0;
        chk_eq("R7 replaying", replaying, 1);
        chk_eq("R8 ready low", wr_ready, 0);
        push(16'hFFFF);
        for (int i = 0; i < 7; i++) begin
            do_tick(0);
            chk_eq("R7 cyclic", smp_out, pat[i % 3]);
        end
        for (int i = 7; i < 13; i++) begin
            do_tick(i % 5);
            chk_eq("R9 varied rate", smp_out, pat[i % 3]);
        end
        chk_eq("R8 write ignored no error", underflow, 0);
        pulse(stop);
        mode_regen = 1'b1;
        pulse(start);
        mode_regen = 1'b0;
        for (int i = 0; i < 4; i++) begin
            do_tick(2);
            chk_eq("R9 restart from first", smp_out, pat[i % 3]);
        end
        pulse(stop);
    endtask

    task automatic t_flush;
        chk_eq("R11 idle after replay", {streaming, replaying}, 0);
        pulse(flush);
        mode_regen = 1'b0;
        pulse(start);
        do_tick(0);
        chk_eq("R11 empty after flush", underflow, 1);
        chk_eq("R11 output held", smp_out, 16'h0A0A);
        pulse(err_clr);
        pulse(stop);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("  [TB] %0d tests run, %0d failed", n_run + 1, n_fail);
        $finish;
    end

    initial begin : main
        t_reset();
        t_stream();
        t_full();
        t_replay();
        t_flush();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule